// File: doc/BRIEF.md
# Event Timer Register Front End and Main Counter

This block is the 32-bit register interface of a multi-channel event timer, and it holds the timer's 64-bit main tick counter. It decodes a 1 KiB register window. The window has a few global registers: a read-only capability word, the tick period, a global configuration word, the interrupt status word and the two counter halves. The window also contains one register group per timer channel, each 32 bytes wide, placed one after another from offset 0x100. The channel comparators and interrupt routing sit in neighbouring blocks. This block gives them write strobes, a decoded channel index and register index, and a shared write data word. It passes their read data back on the bus.

The counter advances by one on each cycle in which the tick enable input is high while the global enable bit is set. When the global enable is cleared, the counter holds its value, and counting resumes from that value when the enable is set again. When software changes the enable bit, the block raises a single-cycle arm or disarm pulse. Channel logic uses the arm pulse to re-arm every channel whose comparator is not all ones, and the disarm pulse to disarm every channel.

Top module: `evt_timer_regs`

## Requirements
- R1: After reset, the counter and the global configuration word both read zero, and the global enable output is low.
- R2: Offset 0x000 reads 0x8086A001 with NUM_TIMERS-1 placed in bits 12:8, so the default of 4 channels reads 0x8086A301. Offset 0x004 reads TICK_PERIOD_FS (default 0x00989680). Writes to either offset change nothing. NUM_TIMERS is clamped to the range 3 to 32 before use.
- R3: In the configuration word at 0x010, bit 0 (enable) and bit 1 (legacy) can be written and read back. All other bits read zero, and offset 0x014 reads zero.
- R4: While enabled, the 64-bit counter increments by exactly one on each clock with the tick enable high, and a carry propagates from the low half into the high half.
- R5: While the enable bit is clear, ticks leave the counter unchanged. Setting the bit again resumes counting from the held value.
- R6: The counter halves at 0x0F0 (low) and 0x0F4 (high) can be read and written, including while the counter is enabled. A half written in the same cycle as a tick takes the written value and does not increment.
- R7: `armAll` is high during a configuration write that sets bit 0 while the enable is clear, and `disarmAll` is high during one that clears bit 0 while the enable is set. A write that leaves bit 0 unchanged raises neither pulse.
- R8: For an access at an offset of 0x100 or above, the channel index is (offset-0x100)/32 and the register index is offset bits 4:2. A write to a valid channel raises `chanWrEn`, and a read to a valid channel returns `chanRdData`.
- R9: A channel index at or above the clamped timer count reads zero and raises no channel write strobe.
- R10: A read of offset 0x020 returns `statusRdData`, and a write to it raises `statusWrEn` for that cycle.
- R11: An access with address bits 1:0 not zero, or to an unmapped global offset, reads zero and changes no state and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Counter advance qualifier, one tick per high cycle |
| busAddr | input | 10 | Byte offset within the register window |
| busWr | input | 1 | Write request for this cycle |
| busRd | input | 1 | Read request for this cycle |
| busWdata | input | 32 | Write data, also forwarded to channel and status logic |
| busRdata | output | 32 | Read data, combinational, zero when busRd is low |
| chanRdData | input | 32 | Read data from channel logic for the decoded channel and register |
| statusRdData | input | 32 | Interrupt status word from status logic |
| chanSel | output | 5 | Decoded channel index |
| chanReg | output | 3 | Decoded 32-bit register index within the channel group |
| chanWrEn | output | 1 | Write strobe to channel logic |
| statusWrEn | output | 1 | Write strobe to status logic |
| globalEn | output | 1 | Global enable bit |
| legacyMode | output | 1 | Legacy routing bit |
| armAll | output | 1 | Pulse: enable is being set |
| disarmAll | output | 1 | Pulse: enable is being cleared |
| counterValue | output | 64 | Current main counter value |

## Verification
The hardest situation to reach from the ports is a counter-half write that lands in the same clock as a tick while the counter runs. Only there does the priority between the load and the increment show. The bench holds the tick enable high across the write cycle only, then reads the half back. It then lets one more tick carry the low half into the high half. A second case that is hard to reach is a freeze under active ticks. For this, the bench disables the counter, runs ticks, and then checks that counting resumes from the held value rather than from zero.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

  localparam int WINDOW_BYTES = 1024;
  localparam int ADDR_W       = $clog2(WINDOW_BYTES);
  localparam int MIN_TIMERS   = 3;
  localparam int MAX_TIMERS   = 32;
  localparam int CHAN_W       = $clog2(MAX_TIMERS);
  localparam int GROUP_BYTES  = 32;
  localparam int GROUP_SHIFT  = $clog2(GROUP_BYTES);
  localparam int REG_W        = GROUP_SHIFT - 2;
  localparam int IDX_W        = ADDR_W - GROUP_SHIFT;

  localparam logic [ADDR_W-1:0] OFF_CAP_LO = 10'h000;
  localparam logic [ADDR_W-1:0] OFF_CAP_HI = 10'h004;
  localparam logic [ADDR_W-1:0] OFF_CFG    = 10'h010;
  localparam logic [ADDR_W-1:0] OFF_STATUS = 10'h020;
  localparam logic [ADDR_W-1:0] OFF_CNT_LO = 10'h0F0;
  localparam logic [ADDR_W-1:0] OFF_CNT_HI = 10'h0F4;
  localparam logic [ADDR_W-1:0] CHAN_BASE  = 10'h100;

  localparam logic [31:0] CAP_BASE = 32'h8086_A001;
  localparam int          CAP_COUNT_LSB = 8;

  typedef enum logic [2:0] {
    RS_ZERO,
    RS_CAP_LO,
    RS_CAP_HI,
    RS_CFG,
    RS_STATUS,
    RS_CNT_LO,
    RS_CNT_HI,
    RS_CHAN
  } rd_sel_e;

  typedef struct packed {
    logic                cfgWr;
    logic                cntLoWr;
    logic                cntHiWr;
    logic                statusWr;
    logic                chanWr;
    logic [CHAN_W-1:0]   chanSel;
    logic [REG_W-1:0]    chanReg;
    rd_sel_e             rdSel;
  } reg_strobe_t;

  function automatic int clampTimers(input int n);
    if (n < MIN_TIMERS) return MIN_TIMERS;
    if (n > MAX_TIMERS) return MAX_TIMERS;
    return n;
  endfunction

endpackage

// File: rtl/evt_reg_decode.sv
module evt_reg_decode
  import evt_timer_pkg::*;
#(
  parameter int NUM_T = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  output reg_strobe_t       stb
);

  logic              aligned;
  logic              inChanRegion;
  logic [ADDR_W-1:0] chanOff;
  logic [IDX_W-1:0]  chanIdx;
  logic              chanValid;

  assign aligned      = (busAddr[1:0] == 2'b00);
  assign inChanRegion = (busAddr >= CHAN_BASE);
  assign chanOff      = busAddr - CHAN_BASE;
  assign chanIdx      = chanOff[ADDR_W-1:GROUP_SHIFT];
  assign chanValid    = inChanRegion && (int'(chanIdx) < NUM_T);

  always_comb begin
    stb          = '0;
    stb.rdSel    = RS_ZERO;
    stb.chanSel  = CHAN_W'(chanIdx);
    stb.chanReg  = chanOff[GROUP_SHIFT-1:2];
    if (aligned) begin
      if (inChanRegion) begin
        if (chanValid) begin
          stb.rdSel  = RS_CHAN;
          stb.chanWr = busWr;
        end
      end else begin
        unique case (busAddr)
          OFF_CAP_LO: stb.rdSel = RS_CAP_LO;
          OFF_CAP_HI: stb.rdSel = RS_CAP_HI;
          OFF_CFG: begin
            stb.rdSel = RS_CFG;
            stb.cfgWr = busWr;
          end
          OFF_STATUS: begin
            stb.rdSel    = RS_STATUS;
            stb.statusWr = busWr;
          end
          OFF_CNT_LO: begin
            stb.rdSel   = RS_CNT_LO;
            stb.cntLoWr = busWr;
          end
          OFF_CNT_HI: begin
            stb.rdSel   = RS_CNT_HI;
            stb.cntHiWr = busWr;
          end
          default: stb.rdSel = RS_ZERO;
        endcase
      end
    end
  end

  // R9: a channel strobe never addresses a channel beyond the clamped count
  assert_chan_range_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.chanWr |-> (int'(stb.chanSel) < NUM_T));

  // R11: misaligned bus cycles raise no write strobe of any kind
  assert_no_misaligned_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr[1:0] != 2'b00) |->
      !(stb.cfgWr || stb.cntLoWr || stb.cntHiWr || stb.statusWr || stb.chanWr));

  // R10: at most one write target per cycle
  assert_one_target_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.cfgWr, stb.cntLoWr, stb.cntHiWr, stb.statusWr, stb.chanWr}));

endmodule

// File: rtl/evt_reg_datapath.sv
module evt_reg_datapath
  import evt_timer_pkg::*;
#(
  parameter int          NUM_T          = 4,
  parameter logic [31:0] TICK_PERIOD_FS = 32'd10_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              busRd,
  input  logic [31:0]       busWdata,
  input  reg_strobe_t       stb,
  input  logic [31:0]       chanRdData,
  input  logic [31:0]       statusRdData,
  output logic [31:0]       busRdata,
  output logic [CHAN_W-1:0] chanSel,
  output logic [REG_W-1:0]  chanReg,
  output logic              chanWrEn,
  output logic              statusWrEn,
  output logic              globalEn,
  output logic              legacyMode,
  output logic              armAll,
  output logic              disarmAll,
  output logic [63:0]       counterValue
);

  localparam logic [31:0] CAP_LO_WORD =
    CAP_BASE | (32'(NUM_T - 1) << CAP_COUNT_LSB);

  logic        cfgEn;
  logic        cfgLeg;
  logic [63:0] count;
  logic [31:0] rdMux;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgEn  <= 1'b0;
      cfgLeg <= 1'b0;
    end else if (stb.cfgWr) begin
      cfgEn  <= busWdata[0];
      cfgLeg <= busWdata[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (stb.cntLoWr) begin
      count[31:0] <= busWdata;
    end else if (stb.cntHiWr) begin
      count[63:32] <= busWdata;
    end else if (cfgEn && tickEn) begin
      count <= count + 64'd1;
    end
  end

  always_comb begin
    unique case (stb.rdSel)
      RS_CAP_LO: rdMux = CAP_LO_WORD;
      RS_CAP_HI: rdMux = TICK_PERIOD_FS;
      RS_CFG:    rdMux = {30'd0, cfgLeg, cfgEn};
      RS_STATUS: rdMux = statusRdData;
      RS_CNT_LO: rdMux = count[31:0];
      RS_CNT_HI: rdMux = count[63:32];
      RS_CHAN:   rdMux = chanRdData;
      default:   rdMux = '0;
    endcase
  end

  assign busRdata     = busRd ? rdMux : 32'd0;
  assign chanSel      = stb.chanSel;
  assign chanReg      = stb.chanReg;
  assign chanWrEn     = stb.chanWr;
  assign statusWrEn   = stb.statusWr;
  assign globalEn     = cfgEn;
  assign legacyMode   = cfgLeg;
  assign armAll       = stb.cfgWr && busWdata[0] && !cfgEn;
  assign disarmAll    = stb.cfgWr && !busWdata[0] && cfgEn;
  assign counterValue = count;

  // R4: one tick while enabled advances the counter by exactly one
  assert_incr_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEn && tickEn && !stb.cntLoWr && !stb.cntHiWr)
      |=> (count == $past(count) + 64'd1));

  // R5: with the enable clear and no load, the counter holds
  assert_freeze_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgEn && !stb.cntLoWr && !stb.cntHiWr) |=> $stable(count));

  // R6: a low-half load wins over a coincident tick
  assert_load_wins_R6: assert property (@(posedge clk) disable iff (!rstN)
    stb.cntLoWr |=> (count[31:0] == $past(busWdata)));

  // R7: an arm pulse leaves the counter enabled, a disarm pulse leaves it halted
  assert_arm_sets_R7: assert property (@(posedge clk) disable iff (!rstN)
    armAll |=> cfgEn);
  assert_disarm_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    disarmAll |=> !cfgEn);

  // R3: configuration changes only through its own write strobe
  assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !stb.cfgWr |=> ($stable(cfgEn) && $stable(cfgLeg)));

endmodule

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
  import evt_timer_pkg::*;
#(
  parameter int          NUM_TIMERS     = 4,
  parameter logic [31:0] TICK_PERIOD_FS = 32'd10_000_000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEn,
  input  logic [9:0]  busAddr,
  input  logic        busWr,
  input  logic        busRd,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  input  logic [31:0] chanRdData,
  input  logic [31:0] statusRdData,
  output logic [4:0]  chanSel,
  output logic [2:0]  chanReg,
  output logic        chanWrEn,
  output logic        statusWrEn,
  output logic        globalEn,
  output logic        legacyMode,
  output logic        armAll,
  output logic        disarmAll,
  output logic [63:0] counterValue
);

  localparam int NUM_T = clampTimers(NUM_TIMERS);

  reg_strobe_t stb;

  evt_reg_decode #(
    .NUM_T(NUM_T)
  ) i_decode (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWr   (busWr),
    .stb     (stb)
  );

  evt_reg_datapath #(
    .NUM_T          (NUM_T),
    .TICK_PERIOD_FS (TICK_PERIOD_FS)
  ) i_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .tickEn       (tickEn),
    .busRd        (busRd),
    .busWdata     (busWdata),
    .stb          (stb),
    .chanRdData   (chanRdData),
    .statusRdData (statusRdData),
    .busRdata     (busRdata),
    .chanSel      (chanSel),
    .chanReg      (chanReg),
    .chanWrEn     (chanWrEn),
    .statusWrEn   (statusWrEn),
    .globalEn     (globalEn),
    .legacyMode   (legacyMode),
    .armAll       (armAll),
    .disarmAll    (disarmAll),
    .counterValue (counterValue)
  );

endmodule

// File: tb/test_evt_timer_regs.sv
module test_evt_timer_regs;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic [9:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] chanRdData;
  logic [31:0] statusRdData;
  logic [4:0]  chanSel;
  logic [2:0]  chanReg;
  logic        chanWrEn;
  logic        statusWrEn;
  logic        globalEn;
  logic        legacyMode;
  logic        armAll;
  logic        disarmAll;
  logic [63:0] counterValue;

  int checks = 0;
  int fails  = 0;

  logic       lastArm, lastDisarm, lastChanWr, lastStatusWr;
  logic [4:0] lastSel;
  logic [2:0] lastReg;

  always #5 clk = ~clk;

  // channel and status models: read data encodes the decoded indices
  assign chanRdData   = {8'hC0, 3'b000, chanSel, 13'd0, chanReg};
  assign statusRdData = 32'h0000_0005;

  evt_timer_regs i_evt_timer_regs (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busAddr(busAddr),
    .busWr(busWr), .busRd(busRd), .busWdata(busWdata), .busRdata(busRdata),
    .chanRdData(chanRdData), .statusRdData(statusRdData), .chanSel(chanSel),
    .chanReg(chanReg), .chanWrEn(chanWrEn), .statusWrEn(statusWrEn),
    .globalEn(globalEn), .legacyMode(legacyMode), .armAll(armAll),
    .disarmAll(disarmAll), .counterValue(counterValue)
  );

  typedef struct packed {
    logic        isWr;
    logic [9:0]  addr;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int VEC_N = 18;
  localparam vec_t VECS [VEC_N] = '{
    '{1'b0, 10'h000, 32'h8086_A301, 4'd2},   // R2 capability low
    '{1'b0, 10'h004, 32'h0098_9680, 4'd2},   // R2 tick period
    '{1'b1, 10'h000, 32'hFFFF_FFFF, 4'd2},   // R2 write ignored
    '{1'b0, 10'h000, 32'h8086_A301, 4'd2},
    '{1'b1, 10'h004, 32'h1234_5678, 4'd2},
    '{1'b0, 10'h004, 32'h0098_9680, 4'd2},
    '{1'b1, 10'h010, 32'hFFFF_FFFE, 4'd3},   // R3 legacy only
    '{1'b0, 10'h010, 32'h0000_0002, 4'd3},
    '{1'b1, 10'h010, 32'h0000_0000, 4'd3},
    '{1'b0, 10'h014, 32'h0000_0000, 4'd3},
    '{1'b0, 10'h020, 32'h0000_0005, 4'd10},  // R10 status read
    '{1'b0, 10'h128, 32'hC001_0002, 4'd8},   // R8 channel 1 reg 2
    '{1'b0, 10'h174, 32'hC003_0005, 4'd8},   // R8 channel 3 reg 5
    '{1'b0, 10'h180, 32'h0000_0000, 4'd9},   // R9 channel 4 out of range
    '{1'b0, 10'h3FC, 32'h0000_0000, 4'd9},   // R9 channel 23
    '{1'b0, 10'h002, 32'h0000_0000, 4'd11},  // R11 misaligned
    '{1'b0, 10'h0F8, 32'h0000_0000, 4'd11},  // R11 unmapped
    '{1'b0, 10'h0F0, 32'h0000_0000, 4'd1}    // R1 counter after reset
  };

  task automatic check(input logic ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [9:0] a, input logic [31:0] d, input logic tk);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1; tickEn = tk;
    #1;
    lastArm = armAll; lastDisarm = disarmAll;
    lastChanWr = chanWrEn; lastStatusWr = statusWrEn;
    lastSel = chanSel; lastReg = chanReg;
    @(negedge clk);
    busWr = 1'b0; tickEn = 1'b0;
  endtask

  task automatic busRead(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1;
    d = busRdata;
    busRd = 1'b0;
  endtask

  task automatic runTicks(input int n);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 2000, 0);
    finishRun();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    check(globalEn == 1'b0, "R1 enable after reset", globalEn, 0);
    busRead(10'h010, rd);
    check(rd == 0, "R1 config after reset", rd, 0);

    for (int i = 0; i < VEC_N; i++) begin
      if (VECS[i].isWr) begin
        busWrite(VECS[i].addr, VECS[i].data, 1'b0);
      end else begin
        busRead(VECS[i].addr, rd);
        checks++;
        if (rd !== VECS[i].data) begin
          fails++;
          $display("FAIL R%0d at %h: actual %h expected %h",
                   VECS[i].req, VECS[i].addr, rd, VECS[i].data);
        end
      end
    end

    // R8 channel write strobe and decoded indices
    busWrite(10'h128, 32'h1, 1'b0);
    check(lastChanWr && lastSel == 5'd1 && lastReg == 3'd2, "R8 channel write",
          {lastChanWr, lastSel, lastReg}, {1'b1, 5'd1, 3'd2});
    // R9 out-of-range channel write raises no strobe
    busWrite(10'h180, 32'h1, 1'b0);
    check(!lastChanWr, "R9 channel write blocked", lastChanWr, 0);
    // R10 status write strobe
    busWrite(10'h020, 32'h3, 1'b0);
    check(lastStatusWr, "R10 status write", lastStatusWr, 1);
    // R11 misaligned config write is ignored
    busWrite(10'h012, 32'h1, 1'b0);
    busRead(10'h010, rd);
    check(rd == 0 && !lastArm && !globalEn, "R11 misaligned write", rd, 0);

    // R6 load while disabled, then R7 arm pulses
    busWrite(10'h0F0, 32'h10, 1'b0);
    busWrite(10'h010, 32'h1, 1'b0);
    check(lastArm && !lastDisarm, "R7 arm pulse", {lastArm, lastDisarm}, 2'b10);
    busWrite(10'h010, 32'h1, 1'b0);
    check(!lastArm && !lastDisarm, "R7 no pulse on same value", {lastArm, lastDisarm}, 0);

    // R4 counting
    runTicks(5);
    busRead(10'h0F0, rd);
    check(rd == 32'h15, "R4 five ticks", rd, 32'h15);

    // R6 load coincident with a tick wins
    busWrite(10'h0F0, 32'hFFFF_FFFF, 1'b1);
    busRead(10'h0F0, rd);
    check(rd == 32'hFFFF_FFFF, "R6 load beats tick", rd, 32'hFFFF_FFFF);

    // R4 carry into the high half
    runTicks(1);
    busRead(10'h0F0, rd);
    check(rd == 0, "R4 carry low", rd, 0);
    busRead(10'h0F4, rd);
    check(rd == 1, "R4 carry high", rd, 1);

    // R6 high-half write while enabled
    busWrite(10'h0F4, 32'hA5, 1'b0);
    busRead(10'h0F4, rd);
    check(rd == 32'hA5, "R6 high write while enabled", rd, 32'hA5);

    // R7 disarm, R5 freeze and resume
    busWrite(10'h010, 32'h0, 1'b0);
    check(lastDisarm && !lastArm, "R7 disarm pulse", {lastArm, lastDisarm}, 2'b01);
    runTicks(4);
    busRead(10'h0F0, rd);
    check(rd == 0, "R5 frozen low", rd, 0);
    check(counterValue == 64'h0000_00A5_0000_0000, "R5 frozen value",
          counterValue, 64'h0000_00A5_0000_0000);
    busWrite(10'h010, 32'h1, 1'b0);
    runTicks(2);
    busRead(10'h0F0, rd);
    check(rd == 2, "R5 resume from held", rd, 2);
    busRead(10'h0F4, rd);
    check(rd == 32'hA5, "R5 resume high", rd, 32'hA5);

    // R1 reset in mid-run
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    busRead(10'h010, rd);
    check(rd == 0 && !globalEn, "R1 config cleared", rd, 0);
    check(counterValue == 0, "R1 counter cleared", counterValue, 0);

    finishRun();
  end

endmodule